// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 16-bit buses, called side A and side B, through two independent 8-bit lanes. Each lane keeps one holding register for traffic heading from A to B and another for traffic heading from B to A. Per lane, a controller picks which side is driven and, for that direction, whether the driven side shows the live value from the opposite bus or the value held in that direction's register. An active-low enable isolates the lane entirely.

Each pad of a bus is split into an input, an output and a per-lane output enable, so the block can be synthesized and a pad ring outside it can form the tri-state pins. All logic runs on one clock. The two capture strobes of a lane are sampled on that clock, and their low-to-high transitions load the holding registers. Lane 0 covers bits 7:0 and lane 1 covers bits 15:8.

Top module: `xcvr_top`

## Requirements
- R1: A synchronous active-high reset `rst` clears both holding registers of every lane to zero. After reset, a lane that drives a side from its register shows 0x00 there.
- R2: While `oe_n[l]` is 1, lane l clears both `a_oe[l]` and `b_oe[l]` and drives zero on its slices of `a_out` and `b_out`.
- R3: While `oe_n[l]` is 0, `dir[l]`=1 makes side B the driven side (`b_oe[l]`=1, `a_oe[l]`=0), and `dir[l]`=0 makes side A the driven side (`a_oe[l]`=1, `b_oe[l]`=0). Exactly one of the two enables is set.
- R4: In transparent mode (`sel_ab[l]`=0 when B is driven, `sel_ba[l]`=0 when A is driven), the driven output slice equals the opposite side's input slice in the same cycle.
- R5: In stored mode (`sel_ab[l]`=1 when B is driven, `sel_ba[l]`=1 when A is driven), the driven output slice equals the register for that direction (the A-to-B register feeds B, and the B-to-A register feeds A).
- R6: A sampled 0-to-1 change of `cap_ab[l]` loads the lane's `a_in` slice into its A-to-B register at that clock edge, whatever `oe_n` and `dir` are, unless side A is the driven side. Holding `cap_ab[l]` high does not reload the register.
- R7: A sampled 0-to-1 change of `cap_ba[l]` loads the lane's `b_in` slice into its B-to-A register in the same way, unless side B is the driven side.
- R8: When a side is driven, a capture edge for the register fed from that side leaves the register unchanged.
- R9: Controls and data of one lane never change the registers or outputs of the other lane.
- R10: In stored mode, a capture edge shows the new register value on the driven side from the cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 2 | Per-lane enable, active low |
| dir | input | 2 | Per-lane driven side: 1 drives B, 0 drives A |
| cap_ab | input | 2 | Per-lane capture strobe for the A-to-B register |
| cap_ba | input | 2 | Per-lane capture strobe for the B-to-A register |
| sel_ab | input | 2 | Per-lane source for B: 0 live A, 1 A-to-B register |
| sel_ba | input | 2 | Per-lane source for A: 0 live B, 1 B-to-A register |
| a_in | input | 16 | Side A pad inputs |
| a_out | output | 16 | Side A pad outputs |
| a_oe | output | 2 | Per-lane output enable for side A |
| b_in | input | 16 | Side B pad inputs |
| b_out | output | 16 | Side B pad outputs |
| b_oe | output | 2 | Per-lane output enable for side B |

## Verification
The properties assume that every control input holds a defined 0 or 1 at each sampled edge. They also assume that a capture strobe counts as an edge only relative to its value at the previous sampled edge, with that value taken as zero during reset. The bench changes every input only just after a falling clock edge, so each input is one steady value per cycle. It draws controls, strobes and data from a seeded generator, so strobes rise, hold and fall in arbitrary patterns. Directed sequences drive the cases where a strobe stays high, where a strobe hits the side being driven, and where one lane keeps still while the other lane is exercised.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int XCVR_LANE_W = 8;
    localparam int XCVR_LANES  = 2;

    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_A    = 2'd1,
        DRV_B    = 2'd2
    } drive_e;

    typedef struct packed {
        logic oe_n;
        logic dir;
        logic cap_ab;
        logic cap_ba;
        logic sel_ab;
        logic sel_ba;
    } lane_ctl_t;

    function automatic drive_e drive_of(input logic oe_n, input logic dir);
        if (oe_n)
            return DRV_NONE;
        return dir ? DRV_B : DRV_A;
    endfunction

endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= '0;
        else
            prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int LW = XCVR_LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  lane_ctl_t     ctl,
    input  logic [LW-1:0] a_in,
    input  logic [LW-1:0] b_in,
    output logic [LW-1:0] a_out,
    output logic [LW-1:0] b_out,
    output logic          a_oe,
    output logic          b_oe,
    output logic [LW-1:0] st_a,
    output logic [LW-1:0] st_b
);
    drive_e     drv;
    logic [1:0] rise;

    assign drv  = drive_of(ctl.oe_n, ctl.dir);
    assign a_oe = (drv == DRV_A);
    assign b_oe = (drv == DRV_B);

    xcvr_edge #(.N(2)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({ctl.cap_ba, ctl.cap_ab}),
        .rise (rise)
    );

    xcvr_store #(.W(LW)) u_st_a (
        .clk  (clk),
        .rst  (rst),
        .load (rise[0] & ~a_oe),
        .d    (a_in),
        .q    (st_a)
    );

    xcvr_store #(.W(LW)) u_st_b (
        .clk  (clk),
        .rst  (rst),
        .load (rise[1] & ~b_oe),
        .d    (b_in),
        .q    (st_b)
    );

    always_comb begin
        a_out = '0;
        b_out = '0;
        case (drv)
            DRV_B:   b_out = ctl.sel_ab ? st_a : a_in;
            DRV_A:   a_out = ctl.sel_ba ? st_b : b_in;
            default: ;
        endcase
    end
endmodule

// File: rtl/xcvr_top.sv
module xcvr_top
    import xcvr_pkg::*;
#(
    parameter int LANE_W = XCVR_LANE_W,
    parameter int LANES  = XCVR_LANES,
    localparam int BUS_W = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] oe_n,
    input  logic [LANES-1:0] dir,
    input  logic [LANES-1:0] cap_ab,
    input  logic [LANES-1:0] cap_ba,
    input  logic [LANES-1:0] sel_ab,
    input  logic [LANES-1:0] sel_ba,
    input  logic [BUS_W-1:0] a_in,
    output logic [BUS_W-1:0] a_out,
    output logic [LANES-1:0] a_oe,
    input  logic [BUS_W-1:0] b_in,
    output logic [BUS_W-1:0] b_out,
    output logic [LANES-1:0] b_oe
);
    logic [BUS_W-1:0] st_a;
    logic [BUS_W-1:0] st_b;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_ctl_t ctl;

        assign ctl = '{oe_n:   oe_n[l],
                       dir:    dir[l],
                       cap_ab: cap_ab[l],
                       cap_ba: cap_ba[l],
                       sel_ab: sel_ab[l],
                       sel_ba: sel_ba[l]};

        xcvr_lane #(.LW(LANE_W)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .ctl   (ctl),
            .a_in  (a_in[l*LANE_W +: LANE_W]),
            .b_in  (b_in[l*LANE_W +: LANE_W]),
            .a_out (a_out[l*LANE_W +: LANE_W]),
            .b_out (b_out[l*LANE_W +: LANE_W]),
            .a_oe  (a_oe[l]),
            .b_oe  (b_oe[l]),
            .st_a  (st_a[l*LANE_W +: LANE_W]),
            .st_b  (st_b[l*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int BUS_W = LANE_W * LANES
) (
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] oe_n,
    input logic [LANES-1:0] dir,
    input logic [LANES-1:0] cap_ab,
    input logic [LANES-1:0] cap_ba,
    input logic [LANES-1:0] sel_ab,
    input logic [LANES-1:0] sel_ba,
    input logic [BUS_W-1:0] a_in,
    input logic [BUS_W-1:0] a_out,
    input logic [LANES-1:0] a_oe,
    input logic [BUS_W-1:0] b_in,
    input logic [BUS_W-1:0] b_out,
    input logic [LANES-1:0] b_oe,
    input logic [BUS_W-1:0] st_a,
    input logic [BUS_W-1:0] st_b
);
    logic [LANES-1:0] pab_q;
    logic [LANES-1:0] pba_q;
    logic [LANES-1:0] up_ab;
    logic [LANES-1:0] up_ba;

    always_ff @(posedge clk) begin
        if (rst) begin
            pab_q <= '0;
            pba_q <= '0;
        end else begin
            pab_q <= cap_ab;
            pba_q <= cap_ba;
        end
    end

    assign up_ab = cap_ab & ~pab_q;
    assign up_ba = cap_ba & ~pba_q;

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        p_isolate_r2: assert property (@(posedge clk) disable iff (rst)
            oe_n[l] |-> (!a_oe[l] && !b_oe[l] &&
                         a_out[l*LANE_W +: LANE_W] == '0 &&
                         b_out[l*LANE_W +: LANE_W] == '0));

        p_one_side_r3: assert property (@(posedge clk) disable iff (rst)
            !oe_n[l] |-> ($countones({a_oe[l], b_oe[l]}) == 1 && b_oe[l] == dir[l]));

        p_live_b_r4: assert property (@(posedge clk) disable iff (rst)
            (b_oe[l] && !sel_ab[l]) |->
                b_out[l*LANE_W +: LANE_W] == a_in[l*LANE_W +: LANE_W]);

        p_live_a_r4: assert property (@(posedge clk) disable iff (rst)
            (a_oe[l] && !sel_ba[l]) |->
                a_out[l*LANE_W +: LANE_W] == b_in[l*LANE_W +: LANE_W]);

        p_stored_b_r5: assert property (@(posedge clk) disable iff (rst)
            (b_oe[l] && sel_ab[l]) |->
                b_out[l*LANE_W +: LANE_W] == st_a[l*LANE_W +: LANE_W]);

        p_stored_a_r5: assert property (@(posedge clk) disable iff (rst)
            (a_oe[l] && sel_ba[l]) |->
                a_out[l*LANE_W +: LANE_W] == st_b[l*LANE_W +: LANE_W]);

        p_load_a_r6: assert property (@(posedge clk) disable iff (rst)
            (up_ab[l] && !a_oe[l]) |=>
                st_a[l*LANE_W +: LANE_W] == $past(a_in[l*LANE_W +: LANE_W]));

        p_load_b_r7: assert property (@(posedge clk) disable iff (rst)
            (up_ba[l] && !b_oe[l]) |=>
                st_b[l*LANE_W +: LANE_W] == $past(b_in[l*LANE_W +: LANE_W]));

        p_keep_a_r8: assert property (@(posedge clk) disable iff (rst)
            !(up_ab[l] && !a_oe[l]) |=> $stable(st_a[l*LANE_W +: LANE_W]));

        p_keep_b_r8: assert property (@(posedge clk) disable iff (rst)
            !(up_ba[l] && !b_oe[l]) |=> $stable(st_b[l*LANE_W +: LANE_W]));
    end
endmodule

bind xcvr_top xcvr_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .oe_n   (oe_n),
    .dir    (dir),
    .cap_ab (cap_ab),
    .cap_ba (cap_ba),
    .sel_ab (sel_ab),
    .sel_ba (sel_ba),
    .a_in   (a_in),
    .a_out  (a_out),
    .a_oe   (a_oe),
    .b_in   (b_in),
    .b_out  (b_out),
    .b_oe   (b_oe),
    .st_a   (st_a),
    .st_b   (st_b)
);

// File: tb/sim_xcvr_top.sv
module sim_xcvr_top;
    localparam int LW = 8;
    localparam int NL = 2;
    localparam int BW = LW * NL;

    logic          clk = 1'b0;
    logic          rst;
    logic [NL-1:0] oe_n, dir, cap_ab, cap_ba, sel_ab, sel_ba;
    logic [BW-1:0] a_in, b_in, a_out, b_out;
    logic [NL-1:0] a_oe, b_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [LW-1:0] m_ra [NL];
    logic [LW-1:0] m_rb [NL];
    logic [NL-1:0] m_pab, m_pba;

    always #4 clk = ~clk;

    xcvr_top u0 (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
        .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic expect_eq(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [LW-1:0] exp_b(input int l);
        if (oe_n[l] || !dir[l]) return '0;
        return sel_ab[l] ? m_ra[l] : a_in[l*LW +: LW];
    endfunction

    function automatic logic [LW-1:0] exp_a(input int l);
        if (oe_n[l] || dir[l]) return '0;
        return sel_ba[l] ? m_rb[l] : b_in[l*LW +: LW];
    endfunction

    // Compare every lane and side with the model (R2, R3, R4, R5).
    task automatic check_all();
        for (int l = 0; l < NL; l++) begin
            string tb_tag, ta_tag;
            tb_tag = oe_n[l] ? "R2" : (!dir[l] ? "R3" : (sel_ab[l] ? "R5" : "R4"));
            ta_tag = oe_n[l] ? "R2" : (dir[l] ? "R3" : (sel_ba[l] ? "R5" : "R4"));
            expect_eq("R3 b_oe", {7'd0, b_oe[l]}, {7'd0, !oe_n[l] && dir[l]});
            expect_eq("R3 a_oe", {7'd0, a_oe[l]}, {7'd0, !oe_n[l] && !dir[l]});
            expect_eq(tb_tag, b_out[l*LW +: LW], exp_b(l));
            expect_eq(ta_tag, a_out[l*LW +: LW], exp_a(l));
        end
    endtask

    // Model of the coming clock edge (R1, R6, R7, R8).
    task automatic tick();
        for (int l = 0; l < NL; l++) begin
            if (rst) begin
                m_ra[l] = '0;
                m_rb[l] = '0;
            end else begin
                if (cap_ab[l] && !m_pab[l] && !(!oe_n[l] && !dir[l]))
                    m_ra[l] = a_in[l*LW +: LW];
                if (cap_ba[l] && !m_pba[l] && !(!oe_n[l] && dir[l]))
                    m_rb[l] = b_in[l*LW +: LW];
            end
        end
        m_pab = rst ? '0 : cap_ab;
        m_pba = rst ? '0 : cap_ba;
        @(negedge clk);
    endtask

    task automatic set_lane(input int l, input logic o, input logic d, input logic ca,
                            input logic cb, input logic sa, input logic sb,
                            input logic [LW-1:0] ai, input logic [LW-1:0] bi);
        oe_n[l] = o; dir[l] = d; cap_ab[l] = ca; cap_ba[l] = cb;
        sel_ab[l] = sa; sel_ba[l] = sb;
        a_in[l*LW +: LW] = ai; b_in[l*LW +: LW] = bi;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        rst = 1'b1;
        oe_n = '1; dir = '0; cap_ab = '0; cap_ba = '0; sel_ab = '0; sel_ba = '0;
        a_in = 16'hFFFF; b_in = 16'hFFFF;
        m_pab = '0; m_pba = '0;
        for (int l = 0; l < NL; l++) begin m_ra[l] = 'x; m_rb[l] = 'x; end
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;

        // R1: registers read back zero after reset in stored mode.
        set_lane(0, 0, 1, 0, 0, 1, 1, 8'hAA, 8'hBB);
        set_lane(1, 0, 0, 0, 0, 1, 1, 8'hCC, 8'hDD);
        #1;
        expect_eq("R1 lane0 B", b_out[7:0], 8'h00);
        expect_eq("R1 lane1 A", a_out[15:8], 8'h00);
        check_all();
        tick();

        // R6 and R10: capture into A-to-B register, visible after the edge.
        set_lane(0, 0, 1, 1, 0, 1, 1, 8'h5A, 8'h00);
        #1;
        expect_eq("R10 before edge", b_out[7:0], 8'h00);
        tick();
        a_in[7:0] = 8'h33;
        #1;
        expect_eq("R10 after edge", b_out[7:0], 8'h5A);
        tick();
        #1;
        expect_eq("R6 held strobe no reload", b_out[7:0], 8'h5A);
        check_all();
        tick();

        // R8: strobe while side A is driven leaves A-to-B register alone.
        set_lane(0, 0, 0, 0, 0, 0, 0, 8'hC3, 8'h11);
        #1; check_all(); tick();
        cap_ab[0] = 1'b1;
        #1; check_all(); tick();
        set_lane(0, 0, 1, 0, 0, 1, 0, 8'h00, 8'h11);
        #1;
        expect_eq("R8 driven side ignored", b_out[7:0], 8'h5A);
        tick();

        // R7: capture into B-to-A register of lane 1 while isolated, then read.
        set_lane(1, 1, 1, 0, 1, 0, 1, 8'h00, 8'h96);
        #1; check_all(); tick();
        set_lane(1, 0, 0, 0, 0, 0, 1, 8'h00, 8'h01);
        #1;
        expect_eq("R7 capture while isolated", a_out[15:8], 8'h96);
        check_all();
        tick();

        // R9: lane 1 churns, lane 0 holds its stored byte.
        set_lane(0, 0, 1, 0, 0, 1, 0, 8'hE7, 8'h00);
        for (int i = 0; i < 40; i++) begin
            set_lane(1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
            #1;
            expect_eq("R9 lane0 unaffected", b_out[7:0], 8'h5A);
            check_all();
            tick();
        end

        // Random mix over both lanes, occasional reset (R1..R8).
        for (int i = 0; i < 4000; i++) begin
            rst = ($urandom_range(0, 199) == 0);
            for (int l = 0; l < NL; l++)
                set_lane(l, ($urandom_range(0, 3) == 0), 1'($urandom),
                         ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0),
                         1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
            #1;
            if (!rst) check_all();
            tick();
        end
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule